// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration slave of a chip. An external controller reaches a small map of byte-wide registers through three wires: an active-low select, a serial clock and one data line whose driver is enabled only while the block is returning data. The block works in the system clock domain. It samples the three serial inputs through a two-stage synchronizer, finds clock edges by comparing successive samples, and runs a frame engine that writes the register array or shifts register contents back out. The whole register array is presented in parallel to the logic it configures.

Every frame opens with a 16-bit instruction. That instruction carries the transfer direction, a two-bit length code and a 13-bit register address. Data bytes follow. A fixed-length transfer moves one to three bytes. A streaming transfer runs until the select rises. The select may be raised at a byte boundary to pause a fixed-length transfer, and the transfer resumes when it falls again. A rise in the middle of a byte cancels the frame. A bit in register 0 switches both instruction and data to least-significant-bit-first order, and it also reverses the direction in which the address steps.

After reset, and until the select is first seen low, the port stays in a strap state. In that state the clock and data inputs are passed through as two static control levels. The strap state ends for good the first time the select goes low.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset, register i of the array holds i*0x11 (register 0 holds 0x00, so MSB-first order applies), `sdo_oe` is 0 and `strap_mode` is 1.
- R2: Instruction word layout: bit 15 is the direction (0 = write, 1 = read), bits 14:13 are the length code, and bits 12:0 are the address. In MSB-first order bit 15 is sent first. On a one-byte write, the register at the address takes the data byte once its eighth bit is clocked in, and other registers keep their values.
- R3: Length codes 00, 01 and 10 move 1, 2 and 3 bytes. Clock cycles after the last byte are ignored until the select rises. In MSB-first order the address decrements after each byte.
- R4: On a read, data bits appear on `sdo` after falling serial-clock edges and are valid at the next rising edge. `sdo_oe` is 1 from the end of the instruction until the last data bit.
- R5: `sdo_oe` is 0 in any cycle in which `cs_n` is high.
- R6: Length code 11 streams bytes to successive addresses until the select rises.
- R7: In a fixed-length transfer, a select rise at a byte boundary pauses the frame. When the select falls again, the frame continues with the next byte of the same transfer, with no new instruction.
- R8: A select rise in the middle of a byte or during the instruction discards the partial byte, leaves every register unchanged and ends the frame. The next select fall starts a new instruction.
- R9: Bit 0 of register 0 set to 1 selects LSB-first order for both instruction and data, starting with the next frame. In that order the address increments after each byte.
- R10: While `strap_mode` is 1, `strap_lvl` bit 1 follows `sclk` and bit 0 follows `sdi`, two clock cycles late. The first time `cs_n` is seen low, `strap_mode` drops to 0 and `strap_lvl` reads 0 until the next reset.
- R11: Addresses at or above the register count are not stored. A write to such an address changes nothing, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the controller |
| sdi | input | 1 | Serial data into the block (input side of the shared line) |
| sdo | output | 1 | Serial read data (output side of the shared line) |
| sdo_oe | output | 1 | Drive enable for the shared data line |
| strap_mode | output | 1 | 1 while the power-up strap state is active |
| strap_lvl | output | 2 | Static levels in strap state: bit 1 clock pin, bit 0 data pin |
| cfg_rows | output | NREG*8 | Register array, register i in bits 8*i+7:8*i |

## Verification
A wrong bit counter or phase state shows up within one byte. The byte lands one bit shifted in `cfg_rows`, or a neighbouring register changes. A wrong address step shows up on the second byte of any burst, because the write lands in the register on the wrong side. A stale bit-order flag or a lost strap clear shows up on the very next frame, as a misaligned instruction or as `strap_lvl` still following the pins. `sdo_oe` is checked against the select in every cycle and against the read data phase at every sampling point.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W   = 13;
  localparam int BYTE_W   = 8;
  localparam int INSTR_W  = ADDR_W + 3;
  localparam int RW_POS   = INSTR_W - 1;
  localparam int LEN_HI   = INSTR_W - 2;
  localparam int LEN_LO   = INSTR_W - 3;
  localparam logic [1:0] LEN_STREAM = 2'b11;
  localparam int ORDER_BIT = 0;

  typedef enum logic [1:0] {
    PH_INSTR = 2'd0,
    PH_DATA  = 2'd1,
    PH_DONE  = 2'd2
  } phase_t;

  function automatic logic [BYTE_W-1:0] row_default(input int idx);
    return BYTE_W'(idx * 17);
  endfunction
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int          W      = 3,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_n;
    if (s == 0) begin : g_first
      assign stg_n = din;
    end else begin : g_next
      assign stg_n = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_n;
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREG-1:0]        row_we,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [NREG*BYTE_W-1:0] rows
);
  for (genvar i = 0; i < NREG; i++) begin : g_row
    logic [BYTE_W-1:0] row_q, row_n;
    always_comb row_n = row_we[i] ? wdata : row_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) row_q <= row_default(i);
      else        row_q <= row_n;
    end
    assign rows[i*BYTE_W +: BYTE_W] = row_q;
  end
endmodule

// File: rtl/spi_cfg_engine.sv
module spi_cfg_engine
  import spi_cfg_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_lvl,
  input  logic              sclk_lvl,
  input  logic              sdi_lvl,
  input  logic              cs_raw_n,
  input  logic              order_cfg,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              wr_en,
  output logic [AW-1:0]     addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int IW = AW + 3;
  localparam int CW = $clog2(IW);
  localparam logic [CW-1:0] LAST_INSTR = CW'(IW - 1);
  localparam logic [CW-1:0] LAST_DATA  = CW'(BYTE_W - 1);

  logic              act_q, act_n;
  phase_t            ph_q, ph_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic [IW-1:0]     sh_q, sh_n;
  logic              rd_q, rd_n, strm_q, strm_n, lsb_q, lsb_n;
  logic [1:0]        left_q, left_n;
  logic [AW-1:0]     addr_q, addr_n;
  logic              sdo_q, sdo_n, rdph_q, rdph_n;
  logic              cs_d_q, sclk_d_q;

  logic              sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [IW-1:0]     word_in;
  logic [BYTE_W-1:0] byte_in;
  logic [2:0]        bit_sel;

  always_comb begin
    sclk_rise = sclk_lvl & ~sclk_d_q;
    sclk_fall = ~sclk_lvl & sclk_d_q;
    cs_fall   = cs_d_q & ~cs_lvl;
    cs_rise   = ~cs_d_q & cs_lvl;
    word_in   = lsb_q ? {sdi_lvl, sh_q[IW-1:1]} : {sh_q[IW-2:0], sdi_lvl};
    byte_in   = lsb_q ? {sdi_lvl, sh_q[BYTE_W-1:1]} : {sh_q[BYTE_W-2:0], sdi_lvl};
    bit_sel   = lsb_q ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);

    act_n = act_q;  ph_n = ph_q;   cnt_n = cnt_q;   sh_n = sh_q;
    rd_n  = rd_q;   strm_n = strm_q; lsb_n = lsb_q; left_n = left_q;
    addr_n = addr_q; sdo_n = sdo_q; rdph_n = rdph_q;
    wr_en = 1'b0;   wr_data = byte_in;

    if (!act_q) begin
      if (cs_fall) begin
        act_n = 1'b1; ph_n = PH_INSTR; cnt_n = '0;
        lsb_n = order_cfg; rdph_n = 1'b0;
      end
    end else if (cs_rise) begin
      if (!(ph_q == PH_DATA && cnt_q == '0 && !strm_q)) begin
        act_n = 1'b0; rdph_n = 1'b0; cnt_n = '0;
      end
    end else if (!cs_lvl && sclk_rise) begin
      unique case (ph_q)
        PH_INSTR: begin
          sh_n  = word_in;
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_INSTR) begin
            rd_n   = word_in[RW_POS];
            left_n = word_in[LEN_HI:LEN_LO];
            strm_n = (word_in[LEN_HI:LEN_LO] == LEN_STREAM);
            addr_n = word_in[AW-1:0];
            rdph_n = word_in[RW_POS];
            ph_n   = PH_DATA;
            cnt_n  = '0;
          end
        end
        PH_DATA: begin
          sh_n  = {sh_q[IW-1:BYTE_W], byte_in};
          cnt_n = cnt_q + 1'b1;
          if (cnt_q == LAST_DATA) begin
            cnt_n  = '0;
            wr_en  = ~rd_q;
            addr_n = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
            if (!strm_q) begin
              if (left_q == 2'd0) begin
                ph_n = PH_DONE; rdph_n = 1'b0;
              end else begin
                left_n = left_q - 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end

    if (act_q && sclk_fall && ph_q == PH_DATA && rd_q) begin
      sdo_n = rd_byte[bit_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; ph_q <= PH_INSTR; cnt_q <= '0; sh_q <= '0;
      rd_q <= 1'b0; strm_q <= 1'b0; lsb_q <= 1'b0; left_q <= '0;
      addr_q <= '0; sdo_q <= 1'b0; rdph_q <= 1'b0;
      cs_d_q <= 1'b1; sclk_d_q <= 1'b0;
    end else begin
      act_q <= act_n; ph_q <= ph_n; cnt_q <= cnt_n; sh_q <= sh_n;
      rd_q <= rd_n; strm_q <= strm_n; lsb_q <= lsb_n; left_q <= left_n;
      addr_q <= addr_n; sdo_q <= sdo_n; rdph_q <= rdph_n;
      cs_d_q <= cs_lvl; sclk_d_q <= sclk_lvl;
    end
  end

  assign addr   = addr_q;
  assign sdo    = sdo_q;
  assign sdo_oe = rdph_q & ~cs_raw_n;
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port
  import spi_cfg_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   sclk,
  input  logic                   sdi,
  output logic                   sdo,
  output logic                   sdo_oe,
  output logic                   strap_mode,
  output logic [1:0]             strap_lvl,
  output logic [NREG*BYTE_W-1:0] cfg_rows
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  logic              cs_lvl, sclk_lvl, sdi_lvl;
  logic              strap_q, strap_n;
  logic              wr_en, in_range;
  logic [ADDR_W-1:0] addr;
  logic [BYTE_W-1:0] wr_data, rd_byte;
  logic [NREG-1:0]   row_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  spi_cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_ni),
    .din  ({cs_n, sclk, sdi}),
    .dout ({cs_lvl, sclk_lvl, sdi_lvl})
  );

  always_comb strap_n = strap_q & cs_lvl;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) strap_q <= 1'b1;
    else         strap_q <= strap_n;
  end
  assign strap_mode = strap_q;
  assign strap_lvl  = strap_q ? {sclk_lvl, sdi_lvl} : 2'b00;

  assign in_range = (addr < ADDR_W'(NREG));
  assign rd_byte  = in_range ? cfg_rows[addr[IDX_W-1:0]*BYTE_W +: BYTE_W] : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign row_we[i] = wr_en & in_range & (addr[IDX_W-1:0] == IDX_W'(i));
  end

  spi_cfg_engine #(.AW(ADDR_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_ni),
    .cs_lvl   (cs_lvl),
    .sclk_lvl (sclk_lvl),
    .sdi_lvl  (sdi_lvl),
    .cs_raw_n (cs_n),
    .order_cfg(cfg_rows[ORDER_BIT]),
    .rd_byte  (rd_byte),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  spi_cfg_regfile #(.NREG(NREG)) u_rf (
    .clk   (clk),
    .rst_n (rst_ni),
    .row_we(row_we),
    .wdata (wr_data),
    .rows  (cfg_rows)
  );
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk #(
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              cs_n,
  input logic              sdo_oe,
  input logic              strap_mode,
  input logic [NREG*8-1:0] cfg_rows,
  input logic [NREG-1:0]   row_we
);
  logic [2:0] cyc_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 1'b1;
  end

  AST_STRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_ni)
    !strap_mode |=> !strap_mode); // R10

  AST_OE_NO_STRAP: assert property (@(posedge clk) disable iff (!rst_ni)
    sdo_oe |-> !strap_mode); // R10

  AST_CFG_HOLD_DESELECT: assert property (@(posedge clk) disable iff (!rst_ni)
    (cyc_q >= 3'd5 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) && $past(cs_n, 4))
      |-> $stable(cfg_rows)); // R8

  AST_ONE_ROW_WRITE: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(row_we)); // R2

  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(cs_n) |-> !sdo_oe); // R5
endmodule

bind spi_cfg_port spi_cfg_port_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .cs_n      (cs_n),
  .sdo_oe    (sdo_oe),
  .strap_mode(strap_mode),
  .cfg_rows  (cfg_rows),
  .row_we    (row_we)
);

// File: tb/sim_spi_cfg_port.sv
module sim_spi_cfg_port;
  localparam int NREG = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cs_n, sclk, sdi;
  logic sdo, sdo_oe, strap_mode;
  logic [1:0] strap_lvl;
  logic [NREG*8-1:0] cfg_rows;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  logic lsb_mode;
  logic [7:0] tx_b [8];
  logic [7:0] rx_b [8];
  int  stall_at;
  bit  in_rd_data, oe_data_ok, oe_stall_low;

  spi_cfg_port #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .strap_mode(strap_mode),
    .strap_lvl(strap_lvl), .cfg_rows(cfg_rows)
  );

  function automatic logic [7:0] row(input int i);
    return cfg_rows[8*i +: 8];
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b, output logic r);
    sdi = b;
    tick(HALF);
    r = sdo;
    if (in_rd_data && !sdo_oe) oe_data_ok = 1'b0;
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic rd, input logic [1:0] len, input logic [12:0] a, input int nbytes);
    logic [15:0] w;
    logic r;
    w = {rd, len, a};
    oe_data_ok = 1'b1;
    oe_stall_low = 1'b1;
    in_rd_data = 1'b0;
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < 16; i++) put_bit(lsb_mode ? w[i] : w[15-i], r);
    for (int k = 0; k < nbytes; k++) begin
      if (k == stall_at) begin
        tick(HALF);
        cs_n = 1'b1;
        #1;
        if (sdo_oe) oe_stall_low = 1'b0;
        tick(3*HALF);
        if (sdo_oe) oe_stall_low = 1'b0;
        cs_n = 1'b0;
        tick(HALF);
      end
      in_rd_data = rd;
      for (int j = 0; j < 8; j++) begin
        int idx;
        idx = lsb_mode ? j : 7 - j;
        put_bit(tx_b[k][idx], r);
        rx_b[k][idx] = r;
      end
    end
    in_rd_data = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(2*HALF);
  endtask

  task automatic t_reset_strap;
    for (int i = 0; i < NREG; i++) chk("R1 reset row", row(i), 64'(8'(i*17)));
    chk("R1 oe at reset", sdo_oe, 0);
    chk("R1 strap at reset", strap_mode, 1);
    sclk = 1'b1; sdi = 1'b0; tick(4);
    chk("R10 strap level clk", strap_lvl, 2'b10);
    sclk = 1'b0; sdi = 1'b1; tick(4);
    chk("R10 strap level data", strap_lvl, 2'b01);
    sdi = 1'b0; tick(4);
  endtask

  task automatic t_write_read;
    tx_b[0] = 8'h3C;
    frame(1'b0, 2'b00, 13'd2, 1);
    chk("R2 single write", row(2), 8'h3C);
    chk("R2 neighbour kept", row(1), 8'h11);
    chk("R2 neighbour kept hi", row(3), 8'h33);
    chk("R10 strap cleared", strap_mode, 0);
    tx_b[0] = 8'h00;
    frame(1'b1, 2'b00, 13'd2, 1);
    chk("R4 read data", rx_b[0], 8'h3C);
    chk("R4 oe during data", oe_data_ok, 1);
    chk("R5 oe after deselect", sdo_oe, 0);
    sclk = 1'b1; sdi = 1'b1; tick(6);
    chk("R10 strap level gone", strap_lvl, 2'b00);
    sclk = 1'b0; sdi = 1'b0; tick(4);
  endtask

  task automatic t_burst;
    tx_b[0] = 8'hA1; tx_b[1] = 8'hB2; tx_b[2] = 8'hC3; tx_b[3] = 8'hFF;
    frame(1'b0, 2'b10, 13'd5, 4);
    chk("R3 burst byte0", row(5), 8'hA1);
    chk("R3 burst byte1", row(4), 8'hB2);
    chk("R3 burst byte2", row(3), 8'hC3);
    chk("R3 extra byte ignored", row(2), 8'h3C);
    frame(1'b1, 2'b01, 13'd4, 2);
    chk("R3 read burst byte0", rx_b[0], 8'hB2);
    chk("R3 read burst byte1", rx_b[1], 8'hC3);
  endtask

  task automatic t_stream;
    tx_b[0] = 8'h10; tx_b[1] = 8'h20; tx_b[2] = 8'h30; tx_b[3] = 8'h40; tx_b[4] = 8'h50;
    frame(1'b0, 2'b11, 13'd7, 5);
    for (int i = 0; i < 5; i++) chk("R6 stream row", row(7 - i), 64'(tx_b[i]));
  endtask

  task automatic t_stall;
    stall_at = 1;
    frame(1'b1, 2'b01, 13'd6, 2);
    chk("R7 stalled read byte0", rx_b[0], 8'h20);
    chk("R7 stalled read byte1", rx_b[1], 8'h30);
    chk("R5 oe low while stalled", oe_stall_low, 1);
    chk("R4 oe in stalled read", oe_data_ok, 1);
    tx_b[0] = 8'h81; tx_b[1] = 8'h7E;
    frame(1'b0, 2'b01, 13'd5, 2);
    chk("R7 stalled write byte0", row(5), 8'h81);
    chk("R7 stalled write byte1", row(4), 8'h7E);
    stall_at = -1;
  endtask

  task automatic t_abort;
    logic r;
    logic [15:0] w;
    w = {1'b0, 2'b00, 13'd6};
    cs_n = 1'b0; tick(HALF);
    for (int i = 0; i < 16; i++) put_bit(w[15-i], r);
    for (int j = 0; j < 5; j++) put_bit(1'b1, r);
    tick(HALF); cs_n = 1'b1; tick(2*HALF);
    chk("R8 partial byte discarded", row(6), 8'h20);
    cs_n = 1'b0; tick(HALF);
    for (int i = 0; i < 7; i++) put_bit(1'b1, r);
    tick(HALF); cs_n = 1'b1; tick(2*HALF);
    chk("R8 instr abort no change", row(7), 8'h10);
    tx_b[0] = 8'h5A;
    frame(1'b0, 2'b00, 13'd6, 1);
    chk("R8 next frame fresh", row(6), 8'h5A);
  endtask

  task automatic t_oob;
    logic [NREG*8-1:0] snap;
    snap = cfg_rows;
    tx_b[0] = 8'hEE;
    frame(1'b0, 2'b00, 13'h0100, 1);
    chk("R11 oob write ignored", cfg_rows, snap);
    tx_b[0] = 8'h00;
    frame(1'b1, 2'b00, 13'h1F00, 1);
    chk("R11 oob read zero", rx_b[0], 8'h00);
  endtask

  task automatic t_lsb;
    tx_b[0] = 8'h01;
    frame(1'b0, 2'b00, 13'd0, 1);
    chk("R9 order bit set", row(0), 8'h01);
    lsb_mode = 1'b1;
    tx_b[0] = 8'h12; tx_b[1] = 8'h34;
    frame(1'b0, 2'b01, 13'd2, 2);
    chk("R9 lsb write byte0", row(2), 8'h12);
    chk("R9 lsb write byte1 incr", row(3), 8'h34);
    frame(1'b1, 2'b01, 13'd2, 2);
    chk("R9 lsb read byte0", rx_b[0], 8'h12);
    chk("R9 lsb read byte1", rx_b[1], 8'h34);
    tx_b[0] = 8'h00;
    frame(1'b0, 2'b00, 13'd0, 1);
    chk("R9 order bit cleared in lsb", row(0), 8'h00);
    lsb_mode = 1'b0;
    tx_b[0] = 8'h96;
    frame(1'b0, 2'b00, 13'd1, 1);
    chk("R9 back to msb", row(1), 8'h96);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    lsb_mode = 1'b0; stall_at = -1;
    in_rd_data = 1'b0; oe_data_ok = 1'b1; oe_stall_low = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    t_reset_strap();
    t_write_read();
    t_burst();
    t_stream();
    t_stall();
    t_abort();
    t_oob();
    t_lsb();
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule